// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage of an in-order pipeline. Each cycle it looks up the current fetch address in two tables. The first is a direct-mapped table of two-bit hysteresis counters that gives the direction. The second is a small direct-mapped target cache of valid, tag and target triples that gives the destination. From these it returns a taken guess and the address to fetch next.

A taken guess is issued only when the counter leans taken and the target cache holds a matching tag for that address. In every other case the next address is the fetch address plus four.

When a branch resolves later in the pipeline, the resolver presents an update. The update carries the branch address, the real outcome and the real destination, together with the guess that was made for that branch at fetch time. The block trains its counter, fills the target cache on taken outcomes and raises a combinational flag when the earlier guess was wrong, so the pipeline can discard younger work and redirect.

Top module: `bpred_top`

## Requirements
- R1: After reset every counter is in the weakly not-taken state (01) and every target entry is invalid, so any lookup returns not-taken with next address equal to fetch address plus 4.
- R2: A counter in state 10 or 11 predicts taken, and the lookup then returns the stored target, provided the target entry for that address is valid and its tag matches.
- R3: A taken outcome increments the counter and a not-taken outcome decrements it, holding at 11 and at 00. From 00, one taken outcome still leaves the direction not-taken.
- R4: From a strong state, the predicted direction changes only after two consecutive outcomes that disagree with it.
- R5: A taken update writes the entry selected by address bits [IDX+1:2] with valid=1, the upper address bits as tag, and the real target. Any lookup that does not predict taken returns fetch address plus 4.
- R6: A not-taken update leaves the target entry unchanged, including its stored target.
- R7: A fetch address that shares the counter and target index with a stored branch but carries a different tag predicts not-taken with next address plus 4, even when the shared counter leans taken.
- R8: With an update present, the mispredict flag is 1 when the real direction differs from the guessed one, or when both are taken and the guessed target differs from the real one. Otherwise, and whenever no update is present, the flag is 0.
- R9: When a lookup and an update fall in the same cycle, the lookup reflects the table state before that update. The update becomes visible from the next cycle.
- R10: A taken update to an occupied target entry overwrites its tag and target, which evicts any earlier branch that mapped there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_taken | output | 1 | Guess that the fetched instruction is a taken branch |
| pred_npc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_target | input | ADDR_W | Real destination of the resolved branch |
| upd_pred_taken | input | 1 | Direction that was guessed for it at fetch |
| upd_pred_target | input | ADDR_W | Next address that was guessed for it at fetch |
| mispredict | output | 1 | The earlier guess was wrong; flush and redirect |

## Verification
A lookup and a training update can fall in the same cycle, and the address being fetched can be the very branch being trained. The bench provokes this by holding the fetch address on a trained branch while it presents two not-taken updates for that branch. In the cycle before each edge it expects the guess of the old state, and after the edge it expects the new one. The first update moves the counter from strong to weak and leaves the guess taken. The second turns the guess to not-taken with a fall-through address. The same cycles also check the mispredict flag, which the update drives at the same time as the lookup.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    // saturating step of a two-bit hysteresis counter
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (cur == CTR_ST)  ? cur : cur + 2'd1;
        else       nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = bp_pkg::ctr_step(st_q.ctr[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.ctr[i] <= bp_pkg::CTR_WNT;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // upper counter bit carries the direction
    assign rd_taken = st_q.ctr[rd_idx][1];

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int TAG_W = ADDR_W - 2 - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);
    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] tgt;
    } tgt_state_t;

    tgt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx] = 1'b1;
            st_d.tag[wr_idx] = wr_tag;
            st_d.tgt[wr_idx] = wr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_hit    = st_q.vld[rd_idx] && (st_q.tag[rd_idx] == rd_tag);
    assign rd_target = st_q.tgt[rd_idx];

endmodule

// File: rtl/bp_resolve_check.sv
module bp_resolve_check #(
    parameter int ADDR_W = 32
) (
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_pred_taken,
    input  logic [ADDR_W-1:0] upd_pred_target,
    output logic              mispredict
);
    logic dir_wrong;
    logic tgt_wrong;

    always_comb begin
        dir_wrong  = upd_taken != upd_pred_taken;
        tgt_wrong  = upd_taken && upd_pred_taken && (upd_target != upd_pred_target);
        mispredict = upd_valid && (dir_wrong || tgt_wrong);
    end

endmodule

// File: rtl/bpred_top.sv
module bpred_top #(
    parameter int ADDR_W      = 32,
    parameter int DIR_ENTRIES = 16,
    parameter int TGT_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_npc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_pred_taken,
    input  logic [ADDR_W-1:0] upd_pred_target,
    output logic              mispredict
);
    localparam int DIR_W = $clog2(DIR_ENTRIES);
    localparam int TGT_W = $clog2(TGT_ENTRIES);
    localparam int TAG_W = ADDR_W - 2 - TGT_W;

    logic              dir_taken;
    logic              tgt_hit;
    logic [ADDR_W-1:0] tgt_addr;
    logic [1:0]        unused_low_bits;

    assign unused_low_bits = upd_pc[1:0];

    bp_dir_table #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[DIR_W+1:2]),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[DIR_W+1:2]),
        .wr_taken (upd_taken)
    );

    bp_target_buf #(.ADDR_W(ADDR_W), .ENTRIES(TGT_ENTRIES)) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_pc[TGT_W+1:2]),
        .rd_tag    (fetch_pc[ADDR_W-1:TGT_W+2]),
        .rd_hit    (tgt_hit),
        .rd_target (tgt_addr),
        .wr_en     (upd_valid && upd_taken),
        .wr_idx    (upd_pc[TGT_W+1:2]),
        .wr_tag    (upd_pc[ADDR_W-1:TGT_W+2]),
        .wr_target (upd_target)
    );

    bp_resolve_check #(.ADDR_W(ADDR_W)) u_res (
        .upd_valid       (upd_valid),
        .upd_taken       (upd_taken),
        .upd_target      (upd_target),
        .upd_pred_taken  (upd_pred_taken),
        .upd_pred_target (upd_pred_target),
        .mispredict      (mispredict)
    );

    // a taken guess needs both a leaning counter and a tagged target
    always_comb begin
        pred_taken = dir_taken && tgt_hit;
        pred_npc   = pred_taken ? tgt_addr : fetch_pc + ADDR_W'(4);
    end

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_npc,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              upd_pred_taken,
    input logic              mispredict
);
    // set once any taken update has been absorbed since reset
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      seen_q <= 1'b0;
        else if (upd_valid && upd_taken) seen_q <= 1'b1;
    end

    a_r1_empty_no_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !pred_taken);

    a_r5_fallthrough_npc: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_npc == fetch_pc + ADDR_W'(4));

    a_r8_quiet_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !mispredict);

    a_r8_direction_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_taken != upd_pred_taken)) |-> mispredict);

endmodule

bind bpred_top bp_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bpred_top_test.sv
module bpred_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_npc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_pred_taken = 1'b0;
    logic [31:0] upd_pred_target = '0;
    logic        mispredict;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bpred_top uut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_npc(pred_npc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_pred_taken(upd_pred_taken),
        .upd_pred_target(upd_pred_target), .mispredict(mispredict)
    );

    // A and B share counter index 0 and target index 0, tags 8 and 10
    localparam logic [31:0] PA = 32'h100, PB = 32'h140;
    localparam logic [31:0] T1 = 32'h800, T2 = 32'h900, T3 = 32'h700;

    typedef struct packed {
        logic        uv;
        logic [31:0] upc;
        logic        ut;
        logic [31:0] utg;
        logic        upt;
        logic [31:0] uptg;
        logic        emiss;
        logic [31:0] lpc;
        logic        et;
        logic [31:0] enpc;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, PA, 1'b1, T1, 1'b0, PA+4, 1'b1, PA, 1'b1, T1},   // ctr 10, alloc
        '{1'b1, PA, 1'b1, T1, 1'b1, T1,   1'b0, PA, 1'b1, T1},   // ctr 11
        '{1'b1, PA, 1'b1, T1, 1'b1, T1,   1'b0, PA, 1'b1, T1},   // holds 11
        '{1'b1, PA, 1'b0, T2, 1'b1, T1,   1'b1, PA, 1'b1, T1},   // 10, target kept
        '{1'b0, PA, 1'b0, 0,  1'b0, 0,    1'b0, PB, 1'b0, PB+4}, // alias misses
        '{1'b1, PA, 1'b0, T2, 1'b1, T1,   1'b1, PA, 1'b0, PA+4}, // 01
        '{1'b1, PA, 1'b0, T2, 1'b0, PA+4, 1'b0, PA, 1'b0, PA+4}, // 00
        '{1'b1, PA, 1'b0, T2, 1'b0, PA+4, 1'b0, PA, 1'b0, PA+4}, // holds 00
        '{1'b1, PA, 1'b1, T2, 1'b0, PA+4, 1'b1, PA, 1'b0, PA+4}, // 01 only
        '{1'b1, PA, 1'b1, T2, 1'b0, PA+4, 1'b1, PA, 1'b1, T2},   // 10, new target
        '{1'b1, PA, 1'b1, T1, 1'b1, T2,   1'b1, PA, 1'b1, T1},   // target miss
        '{1'b1, PB, 1'b1, T3, 1'b0, PB+4, 1'b1, PA, 1'b0, PA+4}, // B evicts A
        '{1'b0, PA, 1'b0, 0,  1'b0, 0,    1'b0, PB, 1'b1, T3}    // B hits
    };
    localparam string VTAG [NV] = '{
        "R5/R8", "R2", "R3", "R4/R6/R8", "R7", "R4", "R3",
        "R3", "R3", "R10", "R8", "R10", "R10"
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic et, input logic [31:0] enpc,
                        input string req);
        fetch_pc = pc;
        #1;
        check(pred_taken === et, req, "pred_taken", 32'(pred_taken), 32'(et));
        check(pred_npc === enpc, req, "pred_npc", pred_npc, enpc);
    endtask

    task automatic clear_upd();
        upd_valid = 1'b0; upd_taken = 1'b0; upd_pc = '0; upd_target = '0;
        upd_pred_taken = 1'b0; upd_pred_target = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_upd();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: empty tables after reset
        look(PA, 1'b0, PA + 4, "R1");
        look(PB, 1'b0, PB + 4, "R1");
        check(mispredict === 1'b0, "R1", "mispredict idle", 32'(mispredict), 0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            upd_valid = VECS[k].uv; upd_pc = VECS[k].upc; upd_taken = VECS[k].ut;
            upd_target = VECS[k].utg; upd_pred_taken = VECS[k].upt;
            upd_pred_target = VECS[k].uptg;
            #1;
            check(mispredict === VECS[k].emiss, VTAG[k], "mispredict",
                  32'(mispredict), 32'(VECS[k].emiss));
            @(negedge clk);
            clear_upd();
            look(VECS[k].lpc, VECS[k].et, VECS[k].enpc, VTAG[k]);
        end

        // R9: lookup and update of the same branch in one cycle (B counter 11)
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = PB; upd_taken = 1'b0; upd_target = T2;
        upd_pred_taken = 1'b1; upd_pred_target = T3;
        look(PB, 1'b1, T3, "R9");
        check(mispredict === 1'b1, "R9", "mispredict same cycle", 32'(mispredict), 1);
        @(negedge clk);
        look(PB, 1'b1, T3, "R9");   // counter 10 now, second update in flight
        @(negedge clk);
        clear_upd();
        look(PB, 1'b0, PB + 4, "R9");

        // R1: reset mid-run wipes trained state
        do_reset();
        look(PB, 1'b0, PB + 4, "R1");
        look(PA, 1'b0, PA + 4, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule